// File: doc/BRIEF.md
# Fully Associative Translation Buffer

The block keeps a handful of recent page translations close to the load/store path. The requester presents a virtual page number and a store flag. The block compares the page number against every stored tag in the same cycle. One cycle later it answers with a hit, the physical page number, and a protection fault flag. The page offset never enters the block; the requester joins it to the returned page number.

When a lookup finds no usable entry, the block raises a request to an external table walker. It then holds its ready output low until the walker answers. It forwards the walker's result as a response. When that result is a present translation, it writes it into an entry chosen by a reference-bit approximation of least-recently-used. A flush input empties every entry at once when the address space changes. An ageing input clears all reference bits.

Each entry carries read-only and dirty state. A store to a read-only page faults at once. A store to a writable page that is not yet dirty goes back to the walker, so the walker can mark the page dirty, and the returned entry replaces the old one in place.

Top module: `xlt_buf`

## Requirements
- R1: After reset every entry is empty, `req_ready` is 1, and both `rsp_valid` and `walk_req_valid` are 0.
- R2: A load, or a store to an entry that is both writable and dirty, that matches a valid tag answers on the next cycle with `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and the stored physical page.
- R3: A store that matches an entry marked read-only answers on the next cycle with `rsp_fault`=1, `rsp_hit`=0 and the stored physical page. It issues no walk and changes no entry.
- R4: A store that matches a writable entry whose dirty bit is 0 is handled as a miss. The walker's answer is written back into that same entry, so no other entry is displaced.
- R5: On a miss, `walk_req_valid` is 1 from the next cycle, carrying the missing page number, and `req_ready` stays 0 until the walker answers. The cycle after `walk_rsp_valid` there is one response with `rsp_hit`=0 and the walker's page. `rsp_fault` is set when the page is absent, or when the request was a store and the walker reports read-only.
- R6: A walker answer with `walk_rsp_present`=0 installs nothing, so the same page misses again.
- R7: The entry that a refill takes is the lowest-index empty entry if there is one. Otherwise it is the lowest-index entry whose reference bit is 0. If every reference bit is 1, all reference bits are cleared and entry 0 is taken.
- R8: A reference bit is set by a hit (R2) and by an install, and `age_clear` clears every reference bit. A hit or an install in the same cycle as `age_clear` still leaves its own bit set.
- R9: `flush` empties every entry by the next cycle, and a lookup in the same cycle as `flush` is treated as a miss.
- R10: A `flush` asserted while a refill is outstanding, including in the cycle of the walker's answer, still delivers the response but installs nothing.
- R11: Placement is fully associative: any eight distinct pages can be resident together and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_vpn | input | 20 | Virtual page number to translate |
| req_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Answer came from a stored entry |
| rsp_fault | output | 1 | Page fault or write-protection fault |
| rsp_ppn | output | 18 | Physical page number |
| walk_req_valid | output | 1 | Refill request to the walker |
| walk_req_vpn | output | 20 | Page the walker must resolve |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_present | input | 1 | Walker found a valid translation |
| walk_rsp_ppn | input | 18 | Physical page from the walker |
| walk_rsp_ronly | input | 1 | Page is read-only |
| walk_rsp_dirty | input | 1 | Page is already dirty |
| flush | input | 1 | Invalidate all entries |
| age_clear | input | 1 | Clear all reference bits |

## Verification
A flush can coincide with a lookup, and a flush or an ageing pulse can coincide with the walker's answer. The bench provokes each collision by raising `flush` together with `req_valid`, or raising `flush` or `age_clear` together with `walk_rsp_valid`. A behavioural model applies the rules of R8, R9 and R10 to the same inputs. Every cycle, the bench compares the response, the ready and the walk request against that model. Later lookups then show at the ports whether an entry was installed or kept.

// File: rtl/xlt_pkg.sv
// Shared types for the translation buffer.
// Assumes: only one refill may be outstanding at a time.
package xlt_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xlt_state_e;

    typedef enum logic [1:0] {
        LK_HIT  = 2'd0,
        LK_MISS = 2'd1,
        LK_PROT = 2'd2,
        LK_UPGR = 2'd3
    } xlt_outcome_e;

endpackage

// File: rtl/xlt_cam.sv
// Tag comparator bank: compares one key against every tag in parallel.
// Assumes: at most one valid entry carries a given tag, so the lowest
// matching index is the only matching index.
module xlt_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);

    logic [ENTRIES-1:0] match;

    // one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    // encode the lowest matching entry
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlt_victim.sv
// Victim picker: takes the lowest empty entry, otherwise the lowest entry
// whose reference bit is clear, otherwise entry 0 with a request to clear
// all reference bits.
// Assumes: the inputs are the state before this cycle's updates.
module xlt_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] ref_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               all_ref_o
);

    logic found;

    // two-pass priority search, empty entries first
    always_comb begin
        idx_o     = '0;
        found     = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_i[i]) begin
                idx_o = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !ref_i[i]) begin
                idx_o = IDX_W'(i);
                found = 1'b1;
            end
        end
        all_ref_o = !found;
    end

endmodule

// File: rtl/xlt_store.sv
// Entry storage: tag, physical page, permission, dirty, valid and
// reference state for every entry, with one write port and one touch port.
// Assumes: the write and touch ports are never active together, and the
// caller already blocks a write in a flush cycle.
module xlt_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic                          age_clear_i,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [VPN_W-1:0]              wr_tag_i,
    input  logic [PPN_W-1:0]              wr_ppn_i,
    input  logic                          wr_ro_i,
    input  logic                          wr_dirty_i,
    input  logic                          wr_clr_all_i,
    input  logic                          touch_en_i,
    input  logic [IDX_W-1:0]              touch_idx_i,
    output logic [ENTRIES-1:0]            valid_o,
    output logic [ENTRIES-1:0]            ref_o,
    output logic [ENTRIES-1:0][VPN_W-1:0] tag_o,
    output logic [ENTRIES-1:0][PPN_W-1:0] ppn_o,
    output logic [ENTRIES-1:0]            ro_o,
    output logic [ENTRIES-1:0]            dirty_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic wr_here;
        logic touch_here;

        assign wr_here    = wr_en_i && (wr_idx_i == IDX_W'(g));
        assign touch_here = touch_en_i && (touch_idx_i == IDX_W'(g));

        // valid bit: flush empties, a write fills
        always_ff @(posedge clk) begin
            if (!rst_n)       valid_o[g] <= 1'b0;
            else if (flush_i) valid_o[g] <= 1'b0;
            else if (wr_here) valid_o[g] <= 1'b1;
        end

        // reference bit: a write or a touch sets it ahead of any clear
        always_ff @(posedge clk) begin
            if (!rst_n)                          ref_o[g] <= 1'b0;
            else if (wr_here || touch_here)      ref_o[g] <= 1'b1;
            else if (age_clear_i || wr_clr_all_i) ref_o[g] <= 1'b0;
        end

        // translation payload, loaded on a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_o[g]   <= '0;
                ppn_o[g]   <= '0;
                ro_o[g]    <= 1'b0;
                dirty_o[g] <= 1'b0;
            end else if (wr_here) begin
                tag_o[g]   <= wr_tag_i;
                ppn_o[g]   <= wr_ppn_i;
                ro_o[g]    <= wr_ro_i;
                dirty_o[g] <= wr_dirty_i;
            end
        end
    end

endmodule

// File: rtl/xlt_buf.sv
// Fully associative translation buffer top.
// Looks up a page number combinationally and answers one cycle later.
// Sends misses and not-yet-dirty store hits to an external walker, and
// installs the walker's answer into a reference-bit chosen entry.
// Assumes: the walker answers only while walk_req_valid is high, and
// ENTRIES is at least 2.
module xlt_buf
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_store,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_present,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    input  logic             walk_rsp_ronly,
    input  logic             walk_rsp_dirty,
    input  logic             flush,
    input  logic             age_clear
);

    xlt_state_e                  state_q;
    logic [VPN_W-1:0]            pend_vpn_q;
    logic                        pend_store_q;
    logic                        pend_reuse_q;
    logic [IDX_W-1:0]            pend_idx_q;
    logic                        flushed_q;

    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0]            ent_ref;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
    logic [ENTRIES-1:0]            ent_ro;
    logic [ENTRIES-1:0]            ent_dirty;

    logic               look_hit;
    logic [IDX_W-1:0]   look_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_all_ref;
    xlt_outcome_e       outcome;
    logic               accept;
    logic               go_wait;
    logic               walk_done;
    logic               install;
    logic [IDX_W-1:0]   wr_idx;

    // lookup ignores every entry in a flush cycle
    xlt_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) u_cam (
        .valid_i (ent_valid & {ENTRIES{~flush}}),
        .tag_i   (ent_tag),
        .key_i   (req_vpn),
        .hit_o   (look_hit),
        .idx_o   (look_idx)
    );

    xlt_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .valid_i   (ent_valid),
        .ref_i     (ent_ref),
        .idx_o     (vic_idx),
        .all_ref_o (vic_all_ref)
    );

    xlt_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .age_clear_i  (age_clear),
        .wr_en_i      (install),
        .wr_idx_i     (wr_idx),
        .wr_tag_i     (pend_vpn_q),
        .wr_ppn_i     (walk_rsp_ppn),
        .wr_ro_i      (walk_rsp_ronly),
        .wr_dirty_i   (walk_rsp_dirty),
        .wr_clr_all_i (install && !pend_reuse_q && vic_all_ref),
        .touch_en_i   (accept && (outcome == LK_HIT)),
        .touch_idx_i  (look_idx),
        .valid_o      (ent_valid),
        .ref_o        (ent_ref),
        .tag_o        (ent_tag),
        .ppn_o        (ent_ppn),
        .ro_o         (ent_ro),
        .dirty_o      (ent_dirty)
    );

    // classify the lookup against the matching entry's permissions
    always_comb begin
        if (!look_hit)                                    outcome = LK_MISS;
        else if (req_store && ent_ro[look_idx])           outcome = LK_PROT;
        else if (req_store && !ent_dirty[look_idx])       outcome = LK_UPGR;
        else                                              outcome = LK_HIT;
    end

    // handshake and refill control terms
    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE);
        go_wait   = accept && ((outcome == LK_MISS) || (outcome == LK_UPGR));
        walk_done = (state_q == ST_WAIT) && walk_rsp_valid;
        install   = walk_done && walk_rsp_present && !flushed_q && !flush;
        wr_idx    = pend_reuse_q ? pend_idx_q : vic_idx;
    end

    // idle/wait state for the single outstanding refill
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= ST_IDLE;
        else if (go_wait)   state_q <= ST_WAIT;
        else if (walk_done) state_q <= ST_IDLE;
    end

    // capture the missing request for the walker and the install
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vpn_q   <= '0;
            pend_store_q <= 1'b0;
            pend_reuse_q <= 1'b0;
            pend_idx_q   <= '0;
        end else if (go_wait) begin
            pend_vpn_q   <= req_vpn;
            pend_store_q <= req_store;
            pend_reuse_q <= (outcome == LK_UPGR);
            pend_idx_q   <= look_idx;
        end
    end

    // remember a flush seen while the refill is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n)                              flushed_q <= 1'b0;
        else if (go_wait)                        flushed_q <= 1'b0;
        else if ((state_q == ST_WAIT) && flush)  flushed_q <= 1'b1;
    end

    // registered response, from a lookup or from the walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ppn   <= '0;
        end else if (accept && ((outcome == LK_HIT) || (outcome == LK_PROT))) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= (outcome == LK_HIT);
            rsp_fault <= (outcome == LK_PROT);
            rsp_ppn   <= ent_ppn[look_idx];
        end else if (walk_done) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_fault <= !walk_rsp_present || (pend_store_q && walk_rsp_ronly);
            rsp_ppn   <= walk_rsp_ppn;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ppn   <= '0;
        end
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign walk_req_valid = (state_q == ST_WAIT);
    assign walk_req_vpn   = pend_vpn_q;

endmodule

// File: rtl/xlt_buf_chk.sv
// Protocol and state checks for the translation buffer, bound to the top.
// Assumes: entry_valid is the top's per-entry valid vector.
module xlt_buf_chk #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [PPN_W-1:0]   rsp_ppn,
    input logic               walk_req_valid,
    input logic [VPN_W-1:0]   walk_req_vpn,
    input logic               walk_rsp_valid,
    input logic               walk_rsp_present,
    input logic               flush,
    input logic [ENTRIES-1:0] entry_valid
);

    // R5
    walk_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req_valid) |-> $past(req_valid && req_ready));

    // R5
    walk_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R5
    walk_answer_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid) |=> (rsp_valid && !rsp_hit && !walk_req_valid && req_ready));

    // R2
    hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && !rsp_fault));

    // R6
    absent_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && !walk_rsp_present) |=> rsp_fault);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (entry_valid == '0));

    // R10
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready) || (walk_req_valid && walk_rsp_valid)));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (req_ready && !rsp_valid && !walk_req_valid && (entry_valid == '0)));

    logic unused_ppn;
    assign unused_ppn = ^rsp_ppn;

endmodule

bind xlt_buf xlt_buf_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_fault        (rsp_fault),
    .rsp_ppn          (rsp_ppn),
    .walk_req_valid   (walk_req_valid),
    .walk_req_vpn     (walk_req_vpn),
    .walk_rsp_valid   (walk_rsp_valid),
    .walk_rsp_present (walk_rsp_present),
    .flush            (flush),
    .entry_valid      (ent_valid)
);

// File: tb/test_xlt_buf.sv
// Bench: drives lookups and a behavioural walker, and compares the ports
// against a behavioural model on every falling edge.
module test_xlt_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_fault;
    logic [17:0] rsp_ppn;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_present = 1'b0;
    logic [17:0] walk_rsp_ppn = '0;
    logic        walk_rsp_ronly = 1'b0;
    logic        walk_rsp_dirty = 1'b0;
    logic        flush = 1'b0;
    logic        age_clear = 1'b0;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    age_on_rsp = 1'b0;

    always #2.5 clk = ~clk;

    xlt_buf i_xlt_buf (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_vpn          (req_vpn),
        .req_store        (req_store),
        .rsp_valid        (rsp_valid),
        .rsp_hit          (rsp_hit),
        .rsp_fault        (rsp_fault),
        .rsp_ppn          (rsp_ppn),
        .walk_req_valid   (walk_req_valid),
        .walk_req_vpn     (walk_req_vpn),
        .walk_rsp_valid   (walk_rsp_valid),
        .walk_rsp_present (walk_rsp_present),
        .walk_rsp_ppn     (walk_rsp_ppn),
        .walk_rsp_ronly   (walk_rsp_ronly),
        .walk_rsp_dirty   (walk_rsp_dirty),
        .flush            (flush),
        .age_clear        (age_clear)
    );

    // behavioural model state
    bit        m_valid [8];
    bit        m_ref   [8];
    bit        m_ro    [8];
    bit        m_dirty [8];
    bit [19:0] m_tag   [8];
    bit [17:0] m_ppn   [8];
    bit        m_wait, m_wst, m_flushed;
    bit [19:0] m_wvpn;
    int        m_widx;
    bit        m_rv, m_rh, m_rf;
    bit [17:0] m_rp;

    // model update at each rising edge
    always @(posedge clk) begin
        int j, touch, ins;
        bit clr_all;
        started <= 1'b1;
        if (!rst_n) begin
            foreach (m_valid[k]) begin
                m_valid[k] = 0; m_ref[k] = 0;
            end
            m_wait = 0; m_flushed = 0; m_rv = 0; m_rh = 0; m_rf = 0; m_rp = '0;
        end else begin
            touch = -1; ins = -1; clr_all = 0;
            m_rv = 0; m_rh = 0; m_rf = 0; m_rp = '0;
            if (!m_wait && req_valid) begin
                j = -1;
                if (!flush)
                    for (int k = 0; k < 8; k++)
                        if (m_valid[k] && m_tag[k] == req_vpn) j = k;
                if (j < 0 || (req_store && !m_ro[j] && !m_dirty[j])) begin
                    m_wait = 1; m_wvpn = req_vpn; m_wst = req_store;
                    m_widx = j; m_flushed = 0;
                end else if (req_store && m_ro[j]) begin
                    m_rv = 1; m_rf = 1; m_rp = m_ppn[j];
                end else begin
                    m_rv = 1; m_rh = 1; m_rp = m_ppn[j]; touch = j;
                end
            end else if (m_wait && walk_rsp_valid) begin
                m_rv = 1; m_rp = walk_rsp_ppn;
                m_rf = !walk_rsp_present || (m_wst && walk_rsp_ronly);
                if (walk_rsp_present && !m_flushed && !flush) begin
                    ins = m_widx;
                    if (ins < 0) begin
                        for (int k = 7; k >= 0; k--) if (!m_ref[k]) ins = k;
                        for (int k = 7; k >= 0; k--) if (!m_valid[k]) ins = k;
                        if (ins < 0) begin ins = 0; clr_all = 1; end
                    end
                end
                m_wait = 0;
            end else if (m_wait && flush) begin
                m_flushed = 1;
            end
            if (age_clear || clr_all) foreach (m_ref[k]) m_ref[k] = 0;
            if (touch >= 0) m_ref[touch] = 1;
            if (flush) foreach (m_valid[k]) m_valid[k] = 0;
            if (ins >= 0) begin
                m_valid[ins] = 1; m_ref[ins] = 1; m_tag[ins] = m_wvpn;
                m_ppn[ins] = walk_rsp_ppn; m_ro[ins] = walk_rsp_ronly;
                m_dirty[ins] = walk_rsp_dirty;
            end
        end
    end

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
        end
    endtask

    // compare ports against the model away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            check("req_ready", 32'(req_ready), 32'(!m_wait));
            check("walk_req_valid", 32'(walk_req_valid), 32'(m_wait));
            if (m_wait) check("walk_req_vpn", 32'(walk_req_vpn), 32'(m_wvpn));
            check("rsp_valid", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) begin
                check("rsp_hit", 32'(rsp_hit), 32'(m_rh));
                check("rsp_fault", 32'(rsp_fault), 32'(m_rf));
                check("rsp_ppn", 32'(rsp_ppn), 32'(m_rp));
            end
        end
    end

    // page table seen by the bench walker
    function automatic logic [17:0] pt_ppn(input logic [19:0] v);
        return v[17:0] ^ 18'h2A5A5;
    endfunction

    // one lookup; the walker answers after delay cycles, flush at flush_at
    task automatic lookup(input logic [19:0] vpn, input bit st,
                          input int delay = 1, input int flush_at = -1,
                          input bit flush_with_req = 0);
        @(negedge clk);
        req_valid = 1; req_vpn = vpn; req_store = st; flush = flush_with_req;
        @(negedge clk);
        req_valid = 0; req_store = 0; flush = 0;
        if (walk_req_valid) begin
            for (int k = 0; k < delay; k++) begin
                flush = (k == flush_at);
                @(negedge clk);
                flush = 0;
            end
            walk_rsp_valid = 1;
            walk_rsp_present = (vpn[19:16] != 4'hF);
            walk_rsp_ppn = pt_ppn(vpn);
            walk_rsp_ronly = vpn[3];
            walk_rsp_dirty = st | vpn[2];
            flush = (flush_at == delay);
            age_clear = age_on_rsp;
            @(negedge clk);
            walk_rsp_valid = 0; flush = 0; age_clear = 0;
        end
    endtask

    task automatic pulse_age();
        @(negedge clk); age_clear = 1;
        @(negedge clk); age_clear = 0;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++; checks++;
                $display("FAIL watchdog: got %0d cycles expected under 50000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R5";
        lookup(20'h01000, 0, 3);

        cur_req = "R11";
        for (int i = 1; i < 8; i++) lookup(20'h01000 + 20'(i * 4), 0, 1 + i % 3);

        cur_req = "R2";
        for (int i = 0; i < 8; i++) lookup(20'h01000 + 20'(i * 4), 0);
        lookup(20'h01004, 1);

        cur_req = "R3";
        lookup(20'h01008, 1);
        lookup(20'h01008, 0);

        cur_req = "R4";
        lookup(20'h01000, 1, 2);
        lookup(20'h01000, 1);
        for (int i = 0; i < 8; i++) lookup(20'h01000 + 20'(i * 4), 0);

        cur_req = "R8";
        pulse_age();
        lookup(20'h01000, 0);
        lookup(20'h01004, 0);

        cur_req = "R7";
        lookup(20'h02000, 0, 1);
        lookup(20'h01008, 0, 1);
        for (int j = 0; j < 8; j++) if (m_valid[j]) lookup(m_tag[j], 0);
        lookup(20'h03000, 0, 2);
        for (int i = 0; i < 8; i++) lookup(20'h01000 + 20'(i * 4), 0);

        cur_req = "R8";
        age_on_rsp = 1;
        lookup(20'h04000, 0, 1);
        age_on_rsp = 0;
        lookup(20'h05000, 0, 1);
        lookup(20'h04000, 0);

        cur_req = "R6";
        lookup(20'hF0000, 0, 1);
        lookup(20'hF0000, 0, 2);

        cur_req = "R9";
        lookup(20'h04000, 0, 1, -1, 1);
        lookup(20'h04000, 0);
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        lookup(20'h04000, 0, 1);

        cur_req = "R10";
        lookup(20'h06000, 0, 3, 1);
        lookup(20'h06000, 0, 1);
        lookup(20'h07000, 0, 2, 2);
        lookup(20'h07000, 0, 1);
        lookup(20'h07000, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule